// File: doc/BRIEF.md
# Interrupt Controller Register Front End

This block is the 32-bit memory-mapped register front end of a message-signalled interrupt controller. It decodes word accesses into registers for domain configuration, per-source configuration, per-source targets and a message register. It also decodes the arrays that set and clear pending and enable bits, and the registers that set or clear one bit given a source number. One of those number registers accepts a byte-swapped (big-endian) value. The trigger logic and the message generation sit in a neighbouring source gateway. This block only emits single-cycle set/clear strobes to that gateway and reads the gateway's pending, enable and rectified input state back, 32 sources per word.

Each request is presented for one cycle on the request port. A response follows exactly one cycle later, carrying read data and an error flag. The source count is a parameter. Source 0 does not exist: its bit in every array reads as zero and ignores writes.

Top module: `irq_regif`

## Requirements
- R1: Every cycle with `req_valid` high is followed exactly one cycle later by `rsp_valid` high, and `rsp_valid` never rises otherwise. A successful write responds with `rsp_rdata` equal to zero.
- R2: A request whose `req_size` is not 2 (2 encodes 4 bytes; 0, 1 and 3 encode 1, 2 and 8 bytes), or whose address bits 1:0 are not zero, responds with `rsp_err` = 1 and `rsp_rdata` = 0. It changes no state and raises no strobe.
- R3: Only these byte offsets are mapped: 0x0000; 0x0004+4(s-1) and 0x3004+4(s-1) for s = 1..NSRC; the bit-array words 0x1C00, 0x1D00, 0x1E00, 0x1F00 plus 4w for w below NW = ceil((NSRC+1)/32); the number registers 0x1CDC, 0x1DDC, 0x1EDC, 0x1FDC, 0x2000, 0x2004; and 0x3000. Any other offset responds with an error and has no effect.
- R4: Domain word 0x0000: only bit 8 (interrupt enable, driven on `dom_ie`) is writable. A read returns 0x80000000 OR bit 2 set (message delivery mode) OR the enable in bit 8.
- R5: Source configuration word for source s: a write with bit 10 set stores 0; otherwise the write keeps bits 2:0. A read returns the stored value, which also drives `src_mode[3(s-1)+:3]`.
- R6: Target word for source s keeps bits 31:18, 17:12 and 10:0 of a write; bit 11 and the rest read as zero. The value drives `src_target[32(s-1)+:32]`.
- R7: In a write to a bit-array word w, each bit b at 1 strobes source 32w+b: 0x1C00 array sets pending, 0x1D00 clears pending, 0x1E00 sets enable, 0x1F00 clears enable. Source 0 and sources above NSRC are ignored.
- R8: Bit-array reads, bit b of word w for source 32w+b: the 0x1C00 array returns `st_pend`, the 0x1D00 array returns `st_in`, the 0x1E00 array returns `st_en`, the 0x1F00 array returns zero.
- R9: A write of n to 0x1CDC or 0x2000 sets pending; 0x1DDC clears pending; 0x1EDC sets enable; 0x1FDC clears enable. Each acts on source n only if 1 <= n <= NSRC. All six number registers read as zero.
- R10: A write to 0x2004 reverses the byte order of the written word before using it as the source number for set-pending.
- R11: Strobes are one-cycle pulses in the same cycle as the write's response; reads never raise a strobe.
- R12: The message word 0x3000 reads back the last written value with bits 17:12 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | AW | Byte offset |
| req_size | input | 2 | Access size code, 2 = 4 bytes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Access rejected |
| rsp_rdata | output | 32 | Read data |
| dom_ie | output | 1 | Domain interrupt enable |
| src_mode | output | 3*NSRC | Per-source trigger mode, source s at 3(s-1) |
| src_target | output | 32*NSRC | Per-source target word, source s at 32(s-1) |
| st_pend | input | NSRC | Pending state from gateway, bit s = source s |
| st_en | input | NSRC | Enable state from gateway |
| st_in | input | NSRC | Rectified input levels from gateway |
| set_pend | output | NSRC | Set-pending strobes |
| clr_pend | output | NSRC | Clear-pending strobes |
| set_en | output | NSRC | Set-enable strobes |
| clr_en | output | NSRC | Clear-enable strobes |

## Verification
The assertions assume that `req_write`, `req_addr` and `req_size` are at defined values whenever `req_valid` is high. They also assume that `req_write` is held low while reset is active, because the strobe-free read check looks one cycle back. The stimulus drives every request input on the falling edge, keeps `req_write` at zero through reset, and changes the gateway state vectors only while no request is in flight. That way each response reflects the state seen in the request cycle.

// File: rtl/irq_regif.sv
module irq_regif #(
  parameter int NSRC = 40,
  parameter int AW   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  output logic              dom_ie,
  output logic [3*NSRC-1:0] src_mode,
  output logic [32*NSRC-1:0] src_target,
  input  logic [NSRC:1]     st_pend,
  input  logic [NSRC:1]     st_en,
  input  logic [NSRC:1]     st_in,
  output logic [NSRC:1]     set_pend,
  output logic [NSRC:1]     clr_pend,
  output logic [NSRC:1]     set_en,
  output logic [NSRC:1]     clr_en
);
  localparam int NW = (NSRC + 32) / 32;
  localparam int PW = NW * 32;
  localparam logic [AW-1:0] A_ARR     = AW'(4 * NW);
  localparam logic [AW-1:0] A_CFG     = AW'('h0004);
  localparam logic [AW-1:0] A_CFG_END = AW'(4 + 4 * NSRC);
  localparam logic [AW-1:0] A_SIP     = AW'('h1C00);
  localparam logic [AW-1:0] A_SIPN    = AW'('h1CDC);
  localparam logic [AW-1:0] A_CIP     = AW'('h1D00);
  localparam logic [AW-1:0] A_CIPN    = AW'('h1DDC);
  localparam logic [AW-1:0] A_SIE     = AW'('h1E00);
  localparam logic [AW-1:0] A_SIEN    = AW'('h1EDC);
  localparam logic [AW-1:0] A_CIE     = AW'('h1F00);
  localparam logic [AW-1:0] A_CIEN    = AW'('h1FDC);
  localparam logic [AW-1:0] A_LE      = AW'('h2000);
  localparam logic [AW-1:0] A_BE      = AW'('h2004);
  localparam logic [AW-1:0] A_GEN     = AW'('h3000);
  localparam logic [AW-1:0] A_TGT     = AW'('h3004);
  localparam logic [AW-1:0] A_TGT_END = AW'('h3004 + 4 * NSRC);
  localparam logic [31:0]   TGT_KEEP  = 32'hFFFF_F7FF;
  localparam logic [31:0]   GEN_KEEP  = 32'hFFFC_0FFF;

  logic [AW-1:0] a;
  logic          fmt_ok, hit, bad, wr;
  logic          is_dom, is_cfg, is_tgt, is_gen;
  logic          is_sip, is_cip, is_sie, is_cie;
  logic          is_sipn, is_cipn, is_sien, is_cien, is_le, is_be;
  logic [5:0]    widx;
  logic [31:0]   swp, rd_c, gen_q;
  logic [2:0]    mode_q [1:NSRC];
  logic [31:0]   tgt_q  [1:NSRC];
  logic [PW-1:0] pend_p, en_p, in_p;
  logic [NSRC:1] sp_c, cp_c, se_c, ce_c;

  assign a       = req_addr;
  assign fmt_ok  = (req_size == 2'd2) && (a[1:0] == 2'b00);
  assign widx    = a[7:2];
  assign swp     = {req_wdata[7:0], req_wdata[15:8], req_wdata[23:16], req_wdata[31:24]};
  assign is_dom  = (a == '0);
  assign is_cfg  = (a >= A_CFG) && (a < A_CFG_END);
  assign is_tgt  = (a >= A_TGT) && (a < A_TGT_END);
  assign is_gen  = (a == A_GEN);
  assign is_sip  = (a >= A_SIP) && (a < A_SIP + A_ARR);
  assign is_cip  = (a >= A_CIP) && (a < A_CIP + A_ARR);
  assign is_sie  = (a >= A_SIE) && (a < A_SIE + A_ARR);
  assign is_cie  = (a >= A_CIE) && (a < A_CIE + A_ARR);
  assign is_sipn = (a == A_SIPN);
  assign is_cipn = (a == A_CIPN);
  assign is_sien = (a == A_SIEN);
  assign is_cien = (a == A_CIEN);
  assign is_le   = (a == A_LE);
  assign is_be   = (a == A_BE);
  assign hit     = is_dom | is_cfg | is_tgt | is_gen | is_sip | is_cip | is_sie | is_cie |
                   is_sipn | is_cipn | is_sien | is_cien | is_le | is_be;
  assign bad     = !fmt_ok || !hit;
  assign wr      = req_valid && req_write && !bad;

  assign pend_p  = PW'({st_pend, 1'b0});
  assign en_p    = PW'({st_en, 1'b0});
  assign in_p    = PW'({st_in, 1'b0});

  always_comb begin
    rd_c = '0;
    if (is_dom) rd_c = 32'h8000_0004 | {23'b0, dom_ie, 8'b0};
    if (is_gen) rd_c = gen_q;
    for (int s = 1; s <= NSRC; s++) begin
      if (is_cfg && a == AW'(4 * s))          rd_c = {29'b0, mode_q[s]};
      if (is_tgt && a == AW'('h3000 + 4 * s)) rd_c = tgt_q[s];
    end
    for (int w = 0; w < NW; w++) begin
      if (widx == 6'(w)) begin
        if (is_sip) rd_c = pend_p[w*32 +: 32];
        if (is_cip) rd_c = in_p[w*32 +: 32];
        if (is_sie) rd_c = en_p[w*32 +: 32];
      end
    end
  end

  for (genvar s = 1; s <= NSRC; s++) begin : g_src
    localparam int          W  = s / 32;
    localparam int          B  = s % 32;
    localparam logic [31:0] SN = 32'(s);
    logic bit_hit;
    assign bit_hit   = (widx == 6'(W)) && req_wdata[B];
    assign sp_c[s]   = wr && ((is_sip && bit_hit) || ((is_sipn || is_le) && req_wdata == SN) ||
                              (is_be && swp == SN));
    assign cp_c[s]   = wr && ((is_cip && bit_hit) || (is_cipn && req_wdata == SN));
    assign se_c[s]   = wr && ((is_sie && bit_hit) || (is_sien && req_wdata == SN));
    assign ce_c[s]   = wr && ((is_cie && bit_hit) || (is_cien && req_wdata == SN));
    assign src_mode[3*(s-1) +: 3]    = mode_q[s];
    assign src_target[32*(s-1) +: 32] = tgt_q[s];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
      dom_ie    <= 1'b0;
      gen_q     <= '0;
      set_pend  <= '0;
      clr_pend  <= '0;
      set_en    <= '0;
      clr_en    <= '0;
      for (int s = 1; s <= NSRC; s++) begin
        mode_q[s] <= '0;
        tgt_q[s]  <= '0;
      end
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && bad;
      rsp_rdata <= (req_valid && !req_write && !bad) ? rd_c : '0;
      set_pend  <= sp_c;
      clr_pend  <= cp_c;
      set_en    <= se_c;
      clr_en    <= ce_c;
      if (wr && is_dom) dom_ie <= req_wdata[8];
      if (wr && is_gen) gen_q  <= req_wdata & GEN_KEEP;
      for (int s = 1; s <= NSRC; s++) begin
        if (wr && is_cfg && a == AW'(4 * s))
          mode_q[s] <= req_wdata[10] ? 3'b000 : req_wdata[2:0];
        if (wr && is_tgt && a == AW'('h3000 + 4 * s))
          tgt_q[s] <= req_wdata & TGT_KEEP;
      end
    end
  end
endmodule

// File: rtl/irq_regif_chk.sv
module irq_regif_chk #(
  parameter int NSRC = 40,
  parameter int AW   = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic [1:0]    req_size,
  input logic          rsp_valid,
  input logic          rsp_err,
  input logic [31:0]   rsp_rdata,
  input logic          dom_ie,
  input logic [NSRC:1] set_pend,
  input logic [NSRC:1] clr_pend,
  input logic [NSRC:1] set_en,
  input logic [NSRC:1] clr_en
);
  logic any_strobe;
  assign any_strobe = |{set_pend, clr_pend, set_en, clr_en};

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R1
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R1
  AST_BAD_SIZE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_size != 2'd2) |=> rsp_err); // R2
  AST_MISALIGN_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[1:0] != 2'b00) |=> rsp_err); // R2
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rdata == '0 && !any_strobe)); // R2
  AST_GAP_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr >= AW'('h2008) && req_addr < AW'('h3000)) |=> rsp_err); // R3
  AST_DOM_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr == '0 && req_size == 2'd2)
      |=> (rsp_rdata[31:24] == 8'h80 && rsp_rdata[2])); // R4
  AST_IE_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid && req_write && req_addr == '0) |-> $stable(dom_ie)); // R4
  AST_STROBE_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    any_strobe |-> (rsp_valid && !rsp_err)); // R11
  AST_READ_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !$past(req_write)) |-> !any_strobe); // R11
endmodule

bind irq_regif irq_regif_chk #(.NSRC(NSRC), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_size(req_size), .rsp_valid(rsp_valid),
  .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .dom_ie(dom_ie),
  .set_pend(set_pend), .clr_pend(clr_pend), .set_en(set_en), .clr_en(clr_en)
);

// File: tb/test_irq_regif.sv
module test_irq_regif;
  localparam int NS = 40;
  localparam int AW = 16;
  localparam int NWB = (NS + 32) / 32;

  typedef struct {
    logic        err;
    logic [31:0] rd;
    logic [NS:1] sp, cp, se, ce;
    string       tag;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_size = 2'd2;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, rsp_err, dom_ie;
  logic [31:0] rsp_rdata;
  logic [3*NS-1:0] src_mode;
  logic [32*NS-1:0] src_target;
  logic [NS:1] st_pend = '0, st_en = '0, st_in = '0;
  logic [NS:1] set_pend, clr_pend, set_en, clr_en;

  int checks = 0, errors = 0;
  exp_t q[$];
  logic ie_m = 0;
  logic [31:0] gen_m = '0;
  logic [2:0] mode_m [1:NS];
  logic [31:0] tgt_m [1:NS];

  always #5 clk = ~clk;

  irq_regif #(.NSRC(NS), .AW(AW)) i_irq_regif (.*);

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model(input bit wr, input logic [15:0] ad, input logic [1:0] sz,
                       input logic [31:0] wd, inout exp_t e);
    int adi, s, k, n;
    logic [31:0] rd;
    logic [NS:1] st;
    logic mapped;
    adi = int'(ad);
    rd = '0; mapped = 1'b1;
    e.err = 1'b0; e.sp = '0; e.cp = '0; e.se = '0; e.ce = '0;
    if (sz != 2'd2 || ad[1:0] != 2'b00) mapped = 1'b0;
    else if (adi == 0) begin
      rd = 32'h8000_0004 | (32'(ie_m) << 8);
      if (wr) ie_m = wd[8];
    end else if (adi >= 4 && adi <= 4 * NS) begin
      s = adi / 4; rd = {29'b0, mode_m[s]};
      if (wr) mode_m[s] = wd[10] ? 3'b0 : wd[2:0];
    end else if (adi == 'h3000) begin
      rd = gen_m;
      if (wr) gen_m = wd & 32'hFFFC_0FFF;
    end else if (adi >= 'h3004 && adi <= 'h3000 + 4 * NS) begin
      s = (adi - 'h3000) / 4; rd = tgt_m[s];
      if (wr) tgt_m[s] = wd & 32'hFFFF_F7FF;
    end else if (adi >= 'h1C00 && adi < 'h2000 && (adi & 'hFF) < 4 * NWB) begin
      k = (adi - 'h1C00) / 'h100;
      st = (k == 0) ? st_pend : (k == 1) ? st_in : (k == 2) ? st_en : '0;
      for (int b = 0; b < 32; b++) begin
        s = ((adi & 'hFF) / 4) * 32 + b;
        if (s >= 1 && s <= NS) begin
          rd[b] = st[s];
          if (wr && wd[b]) begin
            if (k == 0) e.sp[s] = 1'b1;
            if (k == 1) e.cp[s] = 1'b1;
            if (k == 2) e.se[s] = 1'b1;
            if (k == 3) e.ce[s] = 1'b1;
          end
        end
      end
    end else if (adi == 'h1CDC || adi == 'h1DDC || adi == 'h1EDC || adi == 'h1FDC ||
                 adi == 'h2000 || adi == 'h2004) begin
      n = (adi == 'h2004) ? int'({wd[7:0], wd[15:8], wd[23:16], wd[31:24]}) : int'(wd);
      if (wr && n >= 1 && n <= NS) begin
        if (adi == 'h1CDC || adi == 'h2000 || adi == 'h2004) e.sp[n] = 1'b1;
        if (adi == 'h1DDC) e.cp[n] = 1'b1;
        if (adi == 'h1EDC) e.se[n] = 1'b1;
        if (adi == 'h1FDC) e.ce[n] = 1'b1;
      end
    end else mapped = 1'b0;
    if (!mapped) begin
      e.err = 1'b1; e.sp = '0; e.cp = '0; e.se = '0; e.ce = '0;
    end
    e.rd = (!mapped || wr) ? 32'h0 : rd;
  endtask

  task automatic xfer(input bit wr, input logic [15:0] ad, input logic [31:0] wd,
                      input string tag, input logic [1:0] sz = 2'd2);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = ad; req_size = sz; req_wdata = wd;
    e.tag = tag;
    model(wr, ad, sz, wd, e);
    q.push_back(e);
  endtask

  task automatic drain();
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (q.size() == 0) chk(1'b0, "R1", "unexpected response", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(rsp_err === e.err, e.tag, "err", 64'(rsp_err), 64'(e.err));
        chk(rsp_rdata === e.rd, e.tag, "rdata", 64'(rsp_rdata), 64'(e.rd));
        chk({set_pend, clr_pend} === {e.sp, e.cp}, e.tag, "pend strobes",
            64'(set_pend), 64'(e.sp));
        chk({set_en, clr_en} === {e.se, e.ce}, e.tag, "enable strobes",
            64'(set_en), 64'(e.se));
      end
    end else if (rst_n) begin
      chk({set_pend, clr_pend, set_en, clr_en} === '0, "R11", "strobe without response",
          64'(set_pend | clr_pend), 0);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 1; s <= NS; s++) begin mode_m[s] = '0; tgt_m[s] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rsp_valid === 1'b0 && dom_ie === 1'b0, "R1", "reset outputs",
        64'({rsp_valid, dom_ie}), 0);
    chk(src_mode === '0 && src_target === '0, "R5", "reset config", 64'(src_mode), 0);
    rst_n = 1;

    // R4 domain word
    xfer(0, 16'h0000, 0, "R4");
    xfer(1, 16'h0000, 32'hFFFF_FFFF, "R4");
    xfer(0, 16'h0000, 0, "R4");
    drain();
    chk(dom_ie === 1'b1, "R4", "dom_ie after write", 64'(dom_ie), 1);
    // R2 rejected accesses leave state intact
    xfer(1, 16'h0001, 32'h0, "R2");
    xfer(1, 16'h0000, 32'h0, "R2", 2'd1);
    xfer(0, 16'h0000, 0, "R2", 2'd3);
    xfer(0, 16'h0000, 0, "R2");
    drain();
    chk(dom_ie === 1'b1, "R2", "dom_ie after rejected writes", 64'(dom_ie), 1);
    xfer(1, 16'h0000, 32'h0000_0000, "R4");
    xfer(0, 16'h0000, 0, "R4");

    // R5 source configuration
    xfer(1, 16'h0004, 32'h0000_0005, "R5");
    xfer(1, 16'h001C, 32'hFFFF_FBFB, "R5");
    xfer(1, 16'h00A0, 32'h0000_0406, "R5");
    xfer(0, 16'h0004, 0, "R5");
    xfer(0, 16'h001C, 0, "R5");
    xfer(0, 16'h00A0, 0, "R5");
    drain();
    chk(src_mode[2:0] === 3'd5 && src_mode[20:18] === 3'd3 && src_mode[119:117] === 3'd0,
        "R5", "src_mode port", 64'(src_mode[23:0]), 64'h0C0005);

    // R6 targets, R12 message word
    xfer(1, 16'h300C, 32'hFFFF_FFFF, "R6");
    xfer(1, 16'h30A0, 32'h1234_5678, "R6");
    xfer(0, 16'h300C, 0, "R6");
    xfer(0, 16'h30A0, 0, "R6");
    xfer(1, 16'h3000, 32'hFFFF_FFFF, "R12");
    xfer(0, 16'h3000, 0, "R12");
    drain();
    chk(src_target[95:64] === 32'hFFFF_F7FF, "R6", "src_target port",
        64'(src_target[95:64]), 64'hFFFF_F7FF);

    // R3 unmapped offsets
    xfer(0, 16'h00A4, 0, "R3");
    xfer(1, 16'h30A4, 32'h1, "R3");
    xfer(1, 16'h1C08, 32'hFFFF_FFFF, "R3");
    xfer(0, 16'h1500, 0, "R3");
    xfer(1, 16'h2008, 32'h5, "R3");

    // R7 bit-array writes
    xfer(1, 16'h1C00, 32'hFFFF_FFFF, "R7");
    xfer(1, 16'h1C04, 32'hFFFF_FFFF, "R7");
    xfer(1, 16'h1D04, 32'h0000_0300, "R7");
    xfer(1, 16'h1E00, 32'h8000_0011, "R7");
    xfer(1, 16'h1F04, 32'h0000_0001, "R7");
    xfer(1, 16'h1F00, 32'h0000_0001, "R7");
    drain();

    // R8 bit-array reads
    st_pend = 40'hA5_0000_00F1; st_in = 40'h5A_1234_5678; st_en = 40'hFF_8000_0001;
    xfer(0, 16'h1C00, 0, "R8");
    xfer(0, 16'h1C04, 0, "R8");
    xfer(0, 16'h1D00, 0, "R8");
    xfer(0, 16'h1D04, 0, "R8");
    xfer(0, 16'h1E00, 0, "R8");
    xfer(0, 16'h1E04, 0, "R8");
    xfer(0, 16'h1F00, 0, "R8");
    xfer(0, 16'h1F04, 0, "R8");
    drain();

    // R9 number registers, R10 byte-swapped alias
    xfer(1, 16'h1CDC, 32'd5, "R9");
    xfer(1, 16'h1CDC, 32'd0, "R9");
    xfer(1, 16'h1CDC, 32'd41, "R9");
    xfer(1, 16'h1DDC, 32'd40, "R9");
    xfer(1, 16'h1EDC, 32'd1, "R9");
    xfer(1, 16'h1FDC, 32'd17, "R9");
    xfer(1, 16'h2000, 32'd33, "R9");
    xfer(1, 16'h2004, 32'h2100_0000, "R10");
    xfer(1, 16'h2004, 32'h0000_0021, "R10");
    xfer(1, 16'h2004, 32'h0300_0000, "R10");
    xfer(0, 16'h1CDC, 0, "R9");
    xfer(0, 16'h1FDC, 0, "R9");
    xfer(0, 16'h2004, 0, "R9");
    // R1 back-to-back mix
    xfer(0, 16'h0004, 0, "R1");
    xfer(1, 16'h1E04, 32'h0000_0080, "R1");
    xfer(0, 16'h3000, 0, "R1");
    drain();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule